// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of one cache line in a single-level write-back cache that sits on an atomic, arbitrated bus. Two sides use it. The processor side accepts read and write requests for the line. The bus side watches every transaction on the bus and updates the line when a transaction targets the same block. Besides the four stable states (modified, exclusive, shared, invalid), the controller has three transient states. It holds one of these while it waits for the bus. The bus command it will drive follows from the transient state it is in.

A miss or an ownership upgrade makes the block raise a bus request and wait for a grant. After the grant it drives command and address and waits for the acceptance strobe. Reads and read-exclusives then wait for a single data beat. Upgrades finish at acceptance and carry no data. Snooping continues while the request is pending. If another cache wins the bus with an invalidating transaction for this block, the pending upgrade is rewritten into a read-exclusive, so the data is fetched again. Snoop responses go onto the wired-OR shared and dirty lines in the same cycle as the snooped transaction. The state is kept in two copies, one on the processor side and one on the bus side, and every update writes both.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset `line_state` reads 0 (invalid), `bus_req`, `bus_cmd_valid` and `proc_done` are low, and `proc_ready` is high. State codes: 0 I, 1 S, 2 E, 3 M, 4 I-to-S/E, 5 I-to-M, 6 S-to-M.
- R2: A request accepted by `proc_ready` is a hit in these cases: a read in S, E or M, or a write in M. A hit pulses `proc_done` in the next cycle, raises no bus request and leaves the state unchanged. A write in E moves the line to M in the same way, with no bus activity.
- R3: A read in I moves the line to 4 and issues BusRd (code 1). After the data beat the line is S if `bus_shared_in` was high at acceptance, otherwise E. `proc_done` pulses after the data beat.
- R4: A write in I moves the line to 5 and issues BusRdX (code 2). The line ends in M after the data beat.
- R5: A write in S moves the line to 6 and issues BusUpgr (code 3). The line becomes M and `proc_done` pulses in the cycle after `bus_ack`, with no data beat.
- R6: `bus_req` stays high until `bus_gnt`. In the cycle after the grant, `bus_cmd_valid` is high with the command and `bus_addr` equal to `line_addr`, and it holds until `bus_ack`. For reads and read-exclusives the block then waits for `bus_data`.
- R7: A snoop that matches `line_addr` on a stable line acts as follows. BusRd moves M or E to S. BusRdX or BusUpgr moves S, E or M to I. `snp_dirty` is high in that cycle when the line is M and the command is BusRd or BusRdX. `snp_shared` is high whenever the line holds a copy (S, E, M or 6).
- R8: A line in state 6 that snoops a matching BusRdX or BusUpgr moves to 5, and the command it then drives is BusRdX. This also holds when the snoop arrives in the same cycle as the grant. A matching BusRd leaves it in 6.
- R9: A snoop to a different address changes no state, raises neither response line, and does not disturb a pending bus request.
- R10: When a matching snoop and an accepted processor request fall in the same cycle, the snoop is applied first and the processor request acts on the resulting state.
- R11: A processor request while `proc_ready` is low is ignored. It produces no extra `proc_done` pulse and no state change.
- R12: The processor-side and bus-side state copies always hold the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_addr | input | ADDR_W | Block address of the tracked line |
| proc_valid | input | 1 | Processor request strobe |
| proc_write | input | 1 | 1 = write, 0 = read |
| proc_ready | output | 1 | Controller can accept a request |
| proc_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Command and address driven |
| bus_cmd | output | 2 | 1 BusRd, 2 BusRdX, 3 BusUpgr |
| bus_addr | output | ADDR_W | Address driven with the command |
| bus_ack | input | 1 | Command accepted |
| bus_shared_in | input | 1 | Combined shared line, sampled at acceptance |
| bus_data | input | 1 | Data beat for a read or read-exclusive |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_shared | output | 1 | Shared response for the snooped transaction |
| snp_dirty | output | 1 | Dirty response: this cache supplies the data |
| line_state | output | 3 | Current line state code |

## Verification
A snoop can arrive in the same cycle as another event on the same line. Two collisions are checked. The first is a snoop together with a processor request. The bench sweeps every stable start state, every processor operation, every snoop command, and both matching and foreign addresses, all applied in one cycle. A model in the bench applies the snoop first, then the request, and predicts the response lines, the next state and the bus command that follows. The second collision is a snoop together with the bus grant. The line waits in S-to-M, and the grant and an invalidating snoop are driven in the same cycle. The command driven after the grant must be BusRdX.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [2:0] {
        ST_I  = 3'd0,
        ST_S  = 3'd1,
        ST_E  = 3'd2,
        ST_M  = 3'd3,
        ST_IS = 3'd4,
        ST_IM = 3'd5,
        ST_SM = 3'd6
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPGR = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_CMD  = 2'd2,
        PH_DATA = 2'd3
    } bus_ph_e;

    function automatic logic is_transient(line_st_e s);
        return s[2];
    endfunction

    // The command waiting on the bus is implied by the transient state.
    function automatic bus_cmd_e pending_cmd(line_st_e s);
        case (s)
            ST_IS:   return CMD_RD;
            ST_IM:   return CMD_RDX;
            ST_SM:   return CMD_UPGR;
            default: return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
    import mesi_pkg::*;
(
    input  line_st_e st,
    input  logic     hit,
    input  bus_cmd_e cmd,
    output line_st_e st_nxt,
    output logic     shared,
    output logic     dirty
);
    always_comb begin
        st_nxt = st;
        shared = 1'b0;
        dirty  = 1'b0;
        if (hit) begin
            case (st)
                ST_S, ST_E, ST_M: begin
                    shared = 1'b1;
                    dirty  = (st == ST_M) && (cmd == CMD_RD || cmd == CMD_RDX);
                    if (cmd == CMD_RD)
                        st_nxt = ST_S;
                    else if (cmd == CMD_RDX || cmd == CMD_UPGR)
                        st_nxt = ST_I;
                end
                ST_SM: begin
                    shared = 1'b1;
                    // Another writer won the bus: our copy is gone.
                    if (cmd == CMD_RDX || cmd == CMD_UPGR)
                        st_nxt = ST_IM;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_proc_eval.sv
module mesi_proc_eval
    import mesi_pkg::*;
(
    input  line_st_e st,
    input  logic     valid,
    input  logic     write,
    output line_st_e st_nxt,
    output logic     hit
);
    always_comb begin
        st_nxt = st;
        hit    = 1'b0;
        if (valid) begin
            case (st)
                ST_I: st_nxt = write ? ST_IM : ST_IS;
                ST_S: begin
                    if (write) st_nxt = ST_SM;
                    else       hit    = 1'b1;
                end
                ST_E: begin
                    hit = 1'b1;
                    if (write) st_nxt = ST_M;
                end
                ST_M:    hit = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              proc_valid,
    input  logic              proc_write,
    output logic              proc_ready,
    output logic              proc_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic              bus_shared_in,
    input  logic              bus_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_dirty,
    output logic [2:0]        line_state
);
    typedef struct packed {
        line_st_e proc_st;
        line_st_e bus_st;
        bus_ph_e  ph;
        logic     shr;
        logic     done;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{proc_st: ST_I, bus_st: ST_I, ph: PH_IDLE,
                                   shr: 1'b0, done: 1'b0};

    ctrl_t    ctrl_d, ctrl_q;
    logic     snp_hit;
    line_st_e snp_nxt, base_st, prc_nxt;
    logic     prc_hit;
    logic     prc_take;

    // Shared and exposed to the checker.
    line_st_e proc_tag_st, bus_tag_st;
    assign proc_tag_st = ctrl_q.proc_st;
    assign bus_tag_st  = ctrl_q.bus_st;

    // Snoops are only meaningful while another master can own the bus.
    assign snp_hit = snp_valid && (snp_addr == line_addr)
                     && (ctrl_q.ph == PH_IDLE || ctrl_q.ph == PH_REQ);

    mesi_snoop_eval u_snoop (
        .st     (ctrl_q.bus_st),
        .hit    (snp_hit),
        .cmd    (bus_cmd_e'(snp_cmd)),
        .st_nxt (snp_nxt),
        .shared (snp_shared),
        .dirty  (snp_dirty)
    );

    // Snoop result takes effect before the processor request.
    assign base_st  = snp_hit ? snp_nxt : ctrl_q.proc_st;
    assign prc_take = proc_valid && (ctrl_q.ph == PH_IDLE);

    mesi_proc_eval u_proc (
        .st     (base_st),
        .valid  (prc_take),
        .write  (proc_write),
        .st_nxt (prc_nxt),
        .hit    (prc_hit)
    );

    always_comb begin
        line_st_e work_st;
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        work_st     = prc_nxt;
        case (ctrl_q.ph)
            PH_IDLE: begin
                if (prc_hit) ctrl_d.done = 1'b1;
                if (is_transient(prc_nxt)) ctrl_d.ph = PH_REQ;
            end
            PH_REQ: begin
                if (bus_gnt) ctrl_d.ph = PH_CMD;
            end
            PH_CMD: begin
                if (bus_ack) begin
                    if (ctrl_q.proc_st == ST_SM) begin
                        work_st     = ST_M;
                        ctrl_d.done = 1'b1;
                        ctrl_d.ph   = PH_IDLE;
                    end else begin
                        ctrl_d.shr = bus_shared_in;
                        ctrl_d.ph  = PH_DATA;
                    end
                end
            end
            PH_DATA: begin
                if (bus_data) begin
                    if (ctrl_q.proc_st == ST_IS)
                        work_st = ctrl_q.shr ? ST_S : ST_E;
                    else
                        work_st = ST_M;
                    ctrl_d.done = 1'b1;
                    ctrl_d.ph   = PH_IDLE;
                end
            end
            default: ctrl_d.ph = PH_IDLE;
        endcase
        ctrl_d.proc_st = work_st;
        ctrl_d.bus_st  = work_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    assign proc_ready    = (ctrl_q.ph == PH_IDLE);
    assign proc_done     = ctrl_q.done;
    assign bus_req       = (ctrl_q.ph == PH_REQ);
    assign bus_cmd_valid = (ctrl_q.ph == PH_CMD);
    assign bus_cmd       = bus_cmd_valid ? 2'(pending_cmd(ctrl_q.proc_st)) : 2'd0;
    assign bus_addr      = bus_cmd_valid ? line_addr : '0;
    assign line_state    = 3'(ctrl_q.proc_st);

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] line_addr,
    input logic              proc_valid,
    input logic              proc_write,
    input logic              proc_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_cmd_valid,
    input logic [1:0]        bus_cmd,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_shared,
    input logic              snp_dirty,
    input logic [2:0]        line_state,
    input logic [2:0]        proc_tag_st,
    input logic [2:0]        bus_tag_st
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req); // R6
    AST_CMD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt |=> bus_cmd_valid); // R6
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && !bus_ack |=> bus_cmd_valid && $stable(bus_cmd)); // R6
    AST_UPGR_FROM_SM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && bus_cmd == 2'd3 |-> line_state == 3'd6); // R5
    AST_DIRTY_ONLY_M: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |-> line_state == 3'd3); // R7
    AST_SM_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        line_state == 3'd6 && bus_req && snp_valid && snp_addr == line_addr
        && (snp_cmd == 2'd2 || snp_cmd == 2'd3) |=> line_state == 3'd5); // R8
    AST_E_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        line_state == 3'd2 && proc_ready && proc_valid && proc_write && !snp_valid
        |=> line_state == 3'd3 && !bus_req); // R2
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_addr != line_addr |-> !snp_shared && !snp_dirty); // R9
    AST_TAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        proc_tag_st == bus_tag_st); // R12
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_addr     (line_addr),
    .proc_valid    (proc_valid),
    .proc_write    (proc_write),
    .proc_ready    (proc_ready),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd       (bus_cmd),
    .bus_ack       (bus_ack),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_addr      (snp_addr),
    .snp_shared    (snp_shared),
    .snp_dirty     (snp_dirty),
    .line_state    (line_state),
    .proc_tag_st   (3'(proc_tag_st)),
    .bus_tag_st    (3'(bus_tag_st))
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
    localparam int CLK_NS = 10;
    localparam int AW = 4;
    localparam logic [AW-1:0] LINE  = 4'h5;
    localparam logic [AW-1:0] OTHER = 4'hA;

    logic clk = 1'b0, rst_n = 1'b0;
    logic proc_valid = 0, proc_write = 0, bus_gnt = 0, bus_ack = 0;
    logic bus_shared_in = 0, bus_data = 0, snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [AW-1:0] snp_addr = 0;
    logic proc_ready, proc_done, bus_req, bus_cmd_valid, snp_shared, snp_dirty;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [2:0] line_state;

    int checks = 0, errors = 0;
    bit finished = 0;

    mesi_line_ctrl #(.ADDR_W(AW)) u_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .line_addr(LINE),
        .proc_valid(proc_valid), .proc_write(proc_write),
        .proc_ready(proc_ready), .proc_done(proc_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_ack(bus_ack),
        .bus_shared_in(bus_shared_in), .bus_data(bus_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty), .line_state(line_state)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Model of snoop effect, taken from R7 and R8.
    function automatic void snoop_model(input int st, input int cmd,
                                        output int nst, output int sh, output int dt);
        nst = st; sh = 0; dt = 0;
        if (st == 1 || st == 2 || st == 3) begin
            sh = 1;
            dt = (st == 3 && (cmd == 1 || cmd == 2)) ? 1 : 0;
            if (cmd == 1) nst = 1;
            else if (cmd >= 2) nst = 0;
        end else if (st == 6) begin
            sh = 1;
            if (cmd >= 2) nst = 5;
        end
    endfunction

    // Model of processor effect, taken from R2 to R5.
    function automatic void proc_model(input int st, input int op,
                                       output int nst, output int hit);
        nst = st; hit = 0;
        if (op != 0) begin
            case (st)
                0: nst = (op == 2) ? 5 : 4;
                1: if (op == 2) nst = 6; else hit = 1;
                2: begin hit = 1; if (op == 2) nst = 3; end
                3: hit = 1;
                default: ;
            endcase
        end
    endfunction

    function automatic int cmd_for(input int st);
        return (st == 4) ? 1 : (st == 5) ? 2 : (st == 6) ? 3 : 0;
    endfunction

    task automatic do_reset();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    // Drive one whole bus transaction starting from a pending request.
    task automatic run_bus(input string req, input int exp_cmd, input int sh, input int fin);
        chk({req, " bus_req"}, int'(bus_req), 1);
        step();
        chk({req, " bus_req held"}, int'(bus_req), 1);
        bus_gnt = 1;
        step();
        bus_gnt = 0;
        chk({req, " cmd_valid"}, int'(bus_cmd_valid), 1);
        chk({req, " cmd"}, int'(bus_cmd), exp_cmd);
        chk({req, " addr"}, int'(bus_addr), int'(LINE));
        chk("R11 ready low", int'(proc_ready), 0);
        proc_valid = 1; proc_write = 0;
        step();
        chk("R6 cmd held", int'(bus_cmd_valid), 1);
        bus_ack = 1; bus_shared_in = sh[0];
        step();
        bus_ack = 0; bus_shared_in = 0;
        if (exp_cmd != 3) begin
            chk("R11 no done", int'(proc_done), 0);
            bus_data = 1;
            step();
            bus_data = 0;
        end
        proc_valid = 0;
        chk({req, " final"}, int'(line_state), fin);
        chk({req, " done"}, int'(proc_done), 1);
        step();
        chk("R11 single done", int'(proc_done), 0);
    endtask

    task automatic proc_op(input int op);
        proc_valid = (op != 0); proc_write = (op == 2);
        step();
        proc_valid = 0; proc_write = 0;
    endtask

    task automatic reach(input int st);
        do_reset();
        if (st == 1 || st == 2) begin
            proc_op(1);
            run_bus("R3", 1, (st == 1) ? 1 : 0, st);
        end else if (st == 3) begin
            proc_op(2);
            run_bus("R4", 2, 0, 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 state", int'(line_state), 0);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 cmd_valid", int'(bus_cmd_valid), 0);
        chk("R1 done", int'(proc_done), 0);
        chk("R1 ready", int'(proc_ready), 1);

        // Sweep: start state x processor op x snoop command x address.
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 3; p++)
                for (int c = 0; c < 4; c++)
                    for (int a = 0; a < 2; a++) begin
                        int mid, fin, sh, dt, hit, idx;
                        string tag;
                        reach(s);
                        idx = s * 24 + p * 8 + c * 2 + a;
                        mid = s; sh = 0; dt = 0;
                        if (c != 0 && a == 0) snoop_model(s, c, mid, sh, dt);
                        proc_model(mid, p, fin, hit);
                        if (c != 0 && a == 0 && p != 0) tag = "R10";
                        else if (c != 0 && a == 1) tag = "R9";
                        else if (c != 0) tag = "R7";
                        else if (fin == 4) tag = "R3";
                        else if (fin == 5) tag = "R4";
                        else if (fin == 6) tag = "R5";
                        else tag = "R2";
                        proc_valid = (p != 0); proc_write = (p == 2);
                        snp_valid = (c != 0); snp_cmd = c[1:0];
                        snp_addr = a ? OTHER : LINE;
                        #1;
                        chk({tag, " snp_shared"}, int'(snp_shared), sh);
                        chk({tag, " snp_dirty"}, int'(snp_dirty), dt);
                        step();
                        proc_valid = 0; proc_write = 0; snp_valid = 0;
                        chk({tag, " state"}, int'(line_state), fin);
                        chk({tag, " done"}, int'(proc_done), hit);
                        chk({tag, " bus_req"}, int'(bus_req), (fin >= 4) ? 1 : 0);
                        if (fin >= 4)
                            run_bus(tag, cmd_for(fin), idx % 2,
                                    (fin == 4) ? ((idx % 2 == 1) ? 1 : 2) : 3);
                    end

        // R8/R9: snoops while an upgrade waits for the bus.
        reach(1);
        proc_op(2);
        chk("R5 sm", int'(line_state), 6);
        snp_valid = 1; snp_cmd = 2; snp_addr = OTHER;
        #1 chk("R9 shared", int'(snp_shared), 0);
        step();
        chk("R9 state", int'(line_state), 6);
        chk("R9 req", int'(bus_req), 1);
        snp_cmd = 1; snp_addr = LINE;
        #1 chk("R8 shared on rd", int'(snp_shared), 1);
        step();
        chk("R8 rd keeps sm", int'(line_state), 6);
        snp_cmd = 2;
        step();
        snp_valid = 0;
        chk("R8 to im", int'(line_state), 5);
        run_bus("R8", 2, 0, 3);

        // R8: invalidating snoop in the same cycle as the grant.
        reach(1);
        proc_op(2);
        bus_gnt = 1; snp_valid = 1; snp_cmd = 3; snp_addr = LINE;
        step();
        bus_gnt = 0; snp_valid = 0;
        chk("R8 grant state", int'(line_state), 5);
        chk("R8 grant cmd", int'(bus_cmd), 2);
        chk("R8 grant valid", int'(bus_cmd_valid), 1);
        bus_ack = 1;
        step();
        bus_ack = 0; bus_data = 1;
        step();
        bus_data = 0;
        chk("R8 grant final", int'(line_state), 3);
        chk("R8 grant done", int'(proc_done), 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule